// File: doc/BRIEF.md
# Dependent Bank State Tracker

This block keeps the open or closed state of every bank in a memory device where each pair of neighbouring banks shares one row of sense amplifiers. A sense amplifier row can serve only one of its two banks at a time, so two neighbouring banks can never be open together. The tracker accepts already-decoded row commands, one per clock. Each command carries an operation, a device ID and a bank index. The tracker maintains two vectors: one bit per bank that shows which banks are open, and one bit per sense-amp row that shows which rows are held.

An open request is accepted only when both neighbouring banks are closed. If a neighbour is open, the tracker raises an illegal-open pulse and keeps its state. A close request releases the addressed bank and whichever of its two neighbours is open, together with the sense-amp rows those banks held. Refresh-open and refresh-close follow the same rules as plain open and close. A command whose device ID differs from the configured local ID is ignored. A scheduler reads the two vectors to decide which row commands it may issue next.

Top module: `bank_state_tracker`

## Requirements
- R1: While `rst` is high and after it falls, before any command, every bit of `bank_active` and `amp_busy` is 0 and `act_illegal` is 0.
- R2: An open command (`cmd_op` = 0) to bank b whose neighbours b-1 and b+1 are closed sets `bank_active[b]`, and sets `amp_busy[b]` and `amp_busy[b+1]`. The change is visible after the next rising edge.
- R3: An open command to bank b while bank b-1 or b+1 is open drives `act_illegal` high for exactly the cycle after the edge, and leaves both vectors unchanged.
- R4: A close command (`cmd_op` = 1) to an open bank b clears `bank_active[b]` and clears `amp_busy[b]` and `amp_busy[b+1]`.
- R5: A close command to bank b while bank b+1 is open closes bank b+1 and frees amps b+1 and b+2.
- R6: A close command to bank b while bank b-1 is open closes bank b-1 and frees amps b-1 and b. If b-1 and b+1 are both open, both are closed.
- R7: Refresh-open (`cmd_op` = 2) behaves exactly like open, and refresh-close (`cmd_op` = 3) behaves exactly like close. Bit 0 of `cmd_op` selects close.
- R8: A command whose `cmd_dev` differs from `local_id` changes neither vector and never raises `act_illegal`.
- R9: Adjacency does not wrap. Bank 0 has no lower neighbour and bank NUM_BANKS-1 has no upper neighbour. Amp row k sits between bank k-1 and bank k, and there are NUM_BANKS+1 amp rows.
- R10: No two neighbouring banks are ever open together, and `amp_busy[k]` is 1 exactly when bank k-1 or bank k is open.
- R11: A close command to a bank with no open bank among b-1, b and b+1 changes nothing and raises no flag.
- R12: With `cmd_valid` low the state holds and `act_illegal` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_id | input | DEV_W | ID of the device this tracker models |
| cmd_valid | input | 1 | A row command is present this cycle |
| cmd_op | input | 2 | 0 open, 1 close, 2 refresh-open, 3 refresh-close |
| cmd_dev | input | DEV_W | Device ID carried by the command |
| cmd_bank | input | BANK_W | Bank index carried by the command |
| bank_active | output | NUM_BANKS | One bit per bank, 1 when open |
| amp_busy | output | NUM_BANKS+1 | One bit per sense-amp row, 1 when held |
| act_illegal | output | 1 | One-cycle pulse after a refused open |

## Verification
A wrong bank bit appears at the ports one edge after the command that caused it. The same fault can also show up later: a bank wrongly left open makes a later legal open to its neighbour report illegal. A bank wrongly closed lets a later open to its neighbour succeed, which breaks the no-two-adjacent rule. The amp vector is updated by logic separate from the bank vector, so a wrong clear or set there shows up as a mismatch between the two vectors on the very next cycle. A reference model compared every cycle therefore catches a fault either in the cycle it happens or on the first command that touches that neighbourhood.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    // Widest bank index carried inside the request struct.
    localparam int DBT_IDX_W = 8;

    typedef enum logic [1:0] {
        OP_OPEN       = 2'd0,
        OP_CLOSE      = 2'd1,
        OP_REF_OPEN   = 2'd2,
        OP_REF_CLOSE  = 2'd3
    } row_op_e;

    typedef struct packed {
        logic                 open_req;
        logic                 close_req;
        logic [DBT_IDX_W-1:0] bank;
    } row_req_t;

    // True when bank j lies at distance 0 or 1 from bank c.
    function automatic logic in_reach(input int j, input int c);
        return (j == c) || (j == c + 1) || (j + 1 == c);
    endfunction

endpackage

// File: rtl/dbt_cmd_decode.sv
module dbt_cmd_decode
    import dbt_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int BANK_W = 5
) (
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [DEV_W-1:0]  local_id,
    output row_req_t          req
);
    logic    hit;
    row_op_e op;

    assign hit = cmd_valid && (cmd_dev == local_id);
    assign op  = row_op_e'(cmd_op);

    always_comb begin
        req           = '0;
        req.bank      = DBT_IDX_W'(cmd_bank);
        if (hit) begin
            case (op)
                OP_OPEN, OP_REF_OPEN:   req.open_req  = 1'b1;
                OP_CLOSE, OP_REF_CLOSE: req.close_req = 1'b1;
                default:                req           = req;
            endcase
        end
    end
endmodule

// File: rtl/dbt_guard.sv
module dbt_guard
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS = 32
) (
    input  row_req_t             req,
    input  logic [NUM_BANKS-1:0] bank_active,
    output logic                 act_ok,
    output logic                 act_bad
);
    logic conflict;
    int   tgt;

    assign tgt = int'(req.bank);

    always_comb begin
        conflict = 1'b0;
        for (int j = 0; j < NUM_BANKS; j++) begin
            if (bank_active[j] && (j != tgt) && in_reach(j, tgt))
                conflict = 1'b1;
        end
    end

    assign act_ok  = req.open_req && !conflict && (tgt < NUM_BANKS);
    assign act_bad = req.open_req && conflict;
endmodule

// File: rtl/dbt_bank_cell.sv
module dbt_bank_cell
    import dbt_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  row_req_t req,
    input  logic     act_ok,
    output logic     open_q
);
    int tgt;
    assign tgt = int'(req.bank);

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b0;
        else if (act_ok && (tgt == IDX))
            open_q <= 1'b1;
        else if (req.close_req && in_reach(IDX, tgt))
            open_q <= 1'b0;
    end
endmodule

// File: rtl/dbt_amp_cell.sv
module dbt_amp_cell
    import dbt_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  row_req_t req,
    input  logic     act_ok,
    input  logic     left_open,
    input  logic     right_open,
    output logic     busy_q
);
    int   tgt;
    logic set_amp;
    logic clr_amp;

    assign tgt     = int'(req.bank);
    // Row IDX serves bank IDX-1 on its left and bank IDX on its right.
    assign set_amp = act_ok && ((tgt == IDX) || (tgt + 1 == IDX));
    assign clr_amp = req.close_req &&
                     ((left_open  && in_reach(IDX - 1, tgt)) ||
                      (right_open && in_reach(IDX, tgt)));

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else if (set_amp)
            busy_q <= 1'b1;
        else if (clr_amp)
            busy_q <= 1'b0;
    end
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    parameter int DEV_W     = 5,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int NUM_AMPS = NUM_BANKS + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DEV_W-1:0]     local_id,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [DEV_W-1:0]     cmd_dev,
    input  logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] bank_active,
    output logic [NUM_AMPS-1:0]  amp_busy,
    output logic                 act_illegal
);
    row_req_t req;
    logic     act_ok;
    logic     act_bad;

    dbt_cmd_decode #(.DEV_W(DEV_W), .BANK_W(BANK_W)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_dev   (cmd_dev),
        .cmd_bank  (cmd_bank),
        .local_id  (local_id),
        .req       (req)
    );

    dbt_guard #(.NUM_BANKS(NUM_BANKS)) u_guard (
        .req         (req),
        .bank_active (bank_active),
        .act_ok      (act_ok),
        .act_bad     (act_bad)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dbt_bank_cell #(.IDX(b)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .act_ok (act_ok),
            .open_q (bank_active[b])
        );
    end

    for (genvar k = 0; k < NUM_AMPS; k++) begin : g_amp
        logic lft;
        logic rgt;
        if (k > 0) begin : g_l
            assign lft = bank_active[k-1];
        end else begin : g_l0
            assign lft = 1'b0;
        end
        if (k < NUM_BANKS) begin : g_r
            assign rgt = bank_active[k];
        end else begin : g_r0
            assign rgt = 1'b0;
        end
        dbt_amp_cell #(.IDX(k)) u_amp (
            .clk        (clk),
            .rst        (rst),
            .req        (req),
            .act_ok     (act_ok),
            .left_open  (lft),
            .right_open (rgt),
            .busy_q     (amp_busy[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_illegal <= 1'b0;
        else
            act_illegal <= act_bad;
    end
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
    parameter int NUM_BANKS = 32,
    parameter int DEV_W     = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic [DEV_W-1:0]     local_id,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic [DEV_W-1:0]     cmd_dev,
    input logic [NUM_BANKS-1:0] bank_active,
    input logic [NUM_BANKS:0]   amp_busy,
    input logic                 act_illegal
);
    AST_NO_ADJ_OPEN: assert property (@(posedge clk) disable iff (rst)
        (bank_active & (bank_active >> 1)) == '0); // R10

    AST_AMP_TRACKS: assert property (@(posedge clk) disable iff (rst)
        amp_busy == ({bank_active, 1'b0} | {1'b0, bank_active})); // R10

    AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (rst)
        act_illegal && !$past(rst) |-> bank_active == $past(bank_active)); // R3

    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        act_illegal |-> $past(cmd_valid && (cmd_dev == local_id) && !cmd_op[0])); // R3

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(cmd_valid && (cmd_dev != local_id))
        |-> (bank_active == $past(bank_active)) && !act_illegal); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(!cmd_valid)
        |-> (bank_active == $past(bank_active)) && !act_illegal); // R12
endmodule

bind bank_state_tracker dbt_checker #(.NUM_BANKS(NUM_BANKS), .DEV_W(DEV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .local_id    (local_id),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_dev     (cmd_dev),
    .bank_active (bank_active),
    .amp_busy    (amp_busy),
    .act_illegal (act_illegal)
);

// File: tb/bank_state_tracker_test.sv
module bank_state_tracker_test;
    localparam int NB = 32;
    localparam int DW = 5;
    localparam int BW = $clog2(NB);
    localparam logic [DW-1:0] LOCAL = 5'd3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [1:0]    cmd_op;
    logic [DW-1:0] cmd_dev;
    logic [BW-1:0] cmd_bank;
    logic [NB-1:0] bank_active;
    logic [NB:0]   amp_busy;
    logic          act_illegal;

    int checks = 0;
    int fails  = 0;
    bit m_act[NB];
    bit m_ill;

    always #10 clk = ~clk;

    bank_state_tracker #(.NUM_BANKS(NB), .DEV_W(DW)) uut (
        .clk(clk), .rst(rst), .local_id(LOCAL),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_bank(cmd_bank),
        .bank_active(bank_active), .amp_busy(amp_busy), .act_illegal(act_illegal)
    );

    task automatic compare(input string tag);
        logic [NB-1:0] eb;
        logic [NB:0]   ea;
        for (int j = 0; j < NB; j++) eb[j] = m_act[j];
        for (int k = 0; k <= NB; k++)
            ea[k] = (k > 0 && m_act[k-1]) || (k < NB && m_act[k]);
        checks++;
        if (bank_active !== eb) begin
            fails++;
            $display("FAIL %s bank_active actual=%h expected=%h", tag, bank_active, eb);
        end
        checks++;
        if (amp_busy !== ea) begin
            fails++;
            $display("FAIL %s amp_busy actual=%h expected=%h", tag, amp_busy, ea);
        end
        checks++;
        if (act_illegal !== m_ill) begin
            fails++;
            $display("FAIL %s act_illegal actual=%b expected=%b", tag, act_illegal, m_ill);
        end
    endtask

    // Called at a falling edge: drive, advance the model, compare one cycle later.
    task automatic step(input bit v, input logic [1:0] op, input logic [DW-1:0] dev,
                        input int b, input string tag);
        cmd_valid = v;
        cmd_op    = op;
        cmd_dev   = dev;
        cmd_bank  = BW'(b);
        m_ill = 0;
        if (v && dev == LOCAL) begin
            if (!op[0]) begin
                if ((b > 0 && m_act[b-1]) || (b < NB-1 && m_act[b+1])) m_ill = 1;
                else m_act[b] = 1;
            end else begin
                for (int j = b - 1; j <= b + 1; j++)
                    if (j >= 0 && j < NB) m_act[j] = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=complete");
        finish_run();
    end

    initial begin
        int unsigned lfsr;
        rst = 1; cmd_valid = 0; cmd_op = 0; cmd_dev = LOCAL; cmd_bank = '0;
        for (int j = 0; j < NB; j++) m_act[j] = 0;
        m_ill = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst = 0;
        @(posedge clk); @(negedge clk);
        compare("R1");

        step(1, 2'd0, LOCAL, 5,  "R2");   // open 5
        step(1, 2'd0, LOCAL, 6,  "R3");   // refused: 5 open
        step(1, 2'd0, LOCAL, 4,  "R3");   // refused: 5 open
        step(1, 2'd0, LOCAL, 7,  "R2");   // 5 and 7 both open
        step(1, 2'd1, LOCAL, 6,  "R6");   // closes 5 and 7
        step(1, 2'd0, LOCAL, 10, "R2");
        step(1, 2'd1, LOCAL, 9,  "R5");   // upper neighbour closed
        step(1, 2'd0, LOCAL, 12, "R2");
        step(1, 2'd1, LOCAL, 13, "R6");   // lower neighbour closed
        step(1, 2'd0, LOCAL, 20, "R2");
        step(1, 2'd1, LOCAL, 20, "R4");
        step(1, 2'd1, LOCAL, 15, "R11");  // nothing nearby
        step(1, 2'd0, LOCAL, 0,  "R9");
        step(1, 2'd0, LOCAL, 1,  "R9");   // refused
        step(1, 2'd1, LOCAL, 0,  "R9");
        step(1, 2'd0, LOCAL, 31, "R9");
        step(1, 2'd0, LOCAL, 30, "R9");   // refused
        step(1, 2'd1, LOCAL, 30, "R9");   // closes 31
        step(1, 2'd2, LOCAL, 18, "R7");   // refresh-open
        step(1, 2'd2, LOCAL, 17, "R7");   // refused
        step(1, 2'd3, LOCAL, 19, "R7");   // refresh-close closes 18
        step(1, 2'd0, LOCAL, 8,  "R2");
        step(1, 2'd0, 5'd4,  9,  "R8");   // foreign open, would be illegal
        step(1, 2'd1, 5'd9,  8,  "R8");   // foreign close
        step(0, 2'd1, LOCAL, 8,  "R12");  // idle
        step(0, 2'd0, LOCAL, 9,  "R12");

        lfsr = 32'h1234_5678;
        for (int n = 0; n < 2000; n++) begin
            logic [DW-1:0] d;
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            d = (lfsr[20:18] == 3'd0) ? 5'd7 : LOCAL;
            step(lfsr[31:29] != 3'd0, lfsr[1:0], d, int'(lfsr[12:8]), "R10");
        end
        finish_run();
    end
endmodule